// File: doc/BRIEF.md
# Trace Event Control and Trigger

This block holds a 64-bit control word for a trace unit and applies it to four incoming event pulses. Each event has its own enable bit. An enabled event produces a one-cycle event-element strobe at its index. A trigger enable makes occurrences of event 0 raise a trigger request on a valid/ready output. The trigger's data word carries the trace ID captured when the request was raised, with every data bit above the ID width driven to zero. The output-enable and low-power-override bits leave the block as plain control outputs.

Three fields are optional. Output enable (bit 13), low-power override (bit 12) and trigger enable (bit 11) each exist only while their own capability input is high. While that input is low, the field reads as zero and has no effect. Software writes the word through a one-cycle write strobe and reads it back on a combinational read bus. Writes are only legal while the trace unit reports idle. A write made while it is busy is dropped and sets a sticky error flag.

Once a trigger is pending, further event-0 pulses are merged into it. The merge window runs up to and includes the cycle in which the trigger is accepted.

Top module: `tevc_top`

## Requirements
- R1: After synchronous reset, `rd_data_o`, `elem_o`, `trig_valid_o`, `wr_err_o`, `out_en_o` and `lp_override_o` are all zero.
- R2: Bits 63..14 and 10..4 of the control word are reserved. They always read as zero, and a write of ones to them has no effect.
- R3: Bit 13 depends on `cap_oe_i`, bit 12 on `cap_lpo_i` and bit 11 on `cap_trig_i`. While its capability input is 0, a field reads as 0 and behaves as 0. With `cap_trig_i` low, no trigger is raised.
- R4: `out_en_o` equals the effective bit 13 and `lp_override_o` equals the effective bit 12.
- R5: `elem_o[m]` pulses high in the cycle after `evt_i[m]` is high when enable bit m (bit position m, m = 0..3) is 1. It stays low when that enable bit is 0.
- R6: With the effective bit 11 set and no trigger pending, a high `evt_i[0]` raises `trig_valid_o` in the next cycle. `trig_valid_o` then holds until a cycle with `trig_ready_i` high.
- R7: While a trigger is pending, including its acceptance cycle, further `evt_i[0]` pulses raise no extra trigger. `trig_valid_o` falls in the cycle after acceptance.
- R8: `trig_data_o[ID_W-1:0]` holds `trace_id_i` as sampled in the requesting cycle. Bits above `ID_W` are zero, and the word stays stable while the trigger is pending.
- R9: A write made while `idle_i` is 0 leaves the control word unchanged. It sets `wr_err_o` in the next cycle, and `wr_err_o` stays set until reset.
- R10: A write made while `idle_i` is 1 is visible on `rd_data_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_oe_i | input | 1 | Output-enable field present |
| cap_lpo_i | input | 1 | Low-power-override field present |
| cap_trig_i | input | 1 | Trigger-enable field present |
| idle_i | input | 1 | Trace unit idle; writes allowed |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Effective control word |
| wr_err_o | output | 1 | Sticky flag: write attempted while busy |
| evt_i | input | 4 | Event pulses, index 0..3 |
| elem_o | output | 4 | Event element strobes |
| trace_id_i | input | ID_W | Trace ID for the trigger |
| trig_valid_o | output | 1 | Trigger request valid |
| trig_ready_i | input | 1 | Trigger accepted |
| trig_data_o | output | DATA_W | Zero-extended trace ID |
| out_en_o | output | 1 | Trace output enable |
| lp_override_o | output | 1 | Low-power override |

## Verification
One event-0 pulse can produce both an event element and a trigger request in the same cycle. The bench drives all four events together with element 0 and trigger enabled, then checks the element strobe pattern, the trigger valid flag and the captured ID at the same sample point. It also places a fresh event-0 pulse in the very cycle the pending trigger is accepted. In that case the trigger must drop the cycle after and must not be raised again. A pulse one cycle later must then start a new trigger carrying the new ID.

// File: rtl/tevc_pkg.sv
`timescale 1ns/1ps
package tevc_pkg;
  localparam int CTL_W    = 64;
  localparam int NUM_EVT  = 4;
  localparam int POS_OE   = 13;
  localparam int POS_LPO  = 12;
  localparam int POS_TRIG = 11;

  // every bit that storage keeps; anything else is reserved
  localparam logic [CTL_W-1:0] STORE_MASK =
    (CTL_W'(1) << POS_OE) | (CTL_W'(1) << POS_LPO) |
    (CTL_W'(1) << POS_TRIG) | CTL_W'((1 << NUM_EVT) - 1);

  typedef struct packed {
    logic               out_en;
    logic               lp_ovr;
    logic               trig_en;
    logic [NUM_EVT-1:0] evt_en;
  } ctl_t;

  // fields visible for a given capability set
  function automatic logic [CTL_W-1:0] visible_mask(input logic has_oe,
                                                    input logic has_lpo,
                                                    input logic has_trig);
    logic [CTL_W-1:0] m;
    m = CTL_W'((1 << NUM_EVT) - 1);
    if (has_oe)   m[POS_OE]   = 1'b1;
    if (has_lpo)  m[POS_LPO]  = 1'b1;
    if (has_trig) m[POS_TRIG] = 1'b1;
    return m;
  endfunction

  function automatic ctl_t decode_ctl(input logic [CTL_W-1:0] w);
    ctl_t c;
    c.out_en  = w[POS_OE];
    c.lp_ovr  = w[POS_LPO];
    c.trig_en = w[POS_TRIG];
    c.evt_en  = w[NUM_EVT-1:0];
    return c;
  endfunction
endpackage

// File: rtl/tevc_ctl_reg.sv
`timescale 1ns/1ps
module tevc_ctl_reg
  import tevc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_oe_i,
  input  logic             cap_lpo_i,
  input  logic             cap_trig_i,
  input  logic             idle_i,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  output logic [CTL_W-1:0] rd_data_o,
  output ctl_t             ctl_o,
  output logic             wr_err_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             wr_accept;
  logic             wr_reject;
  logic             err_q;

  assign wr_accept = wr_en_i &  idle_i;
  assign wr_reject = wr_en_i & ~idle_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_accept) ctl_q <= wr_data_i & STORE_MASK;
      if (wr_reject) err_q <= 1'b1;
    end
  end

  assign rd_data_o = ctl_q & visible_mask(cap_oe_i, cap_lpo_i, cap_trig_i);
  assign ctl_o     = decode_ctl(rd_data_o);
  assign wr_err_o  = err_q;

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    wr_reject |=> $stable(ctl_q)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !err_q && !wr_reject |=> !err_q); // R9
endmodule

// File: rtl/tevc_evt_gate.sv
`timescale 1ns/1ps
module tevc_evt_gate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] elem_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic fire;
    logic elem_q;
    assign fire = evt_i[g] & en_i[g];
    always_ff @(posedge clk) begin
      if (rst) elem_q <= 1'b0;
      else     elem_q <= fire;
    end
    assign elem_o[g] = elem_q;

    AST_ELEM_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
      elem_q |-> $past(evt_i[g])); // R5
    AST_ELEM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
      elem_q |-> $past(en_i[g])); // R5
  end
endmodule

// File: rtl/tevc_trig.sv
`timescale 1ns/1ps
module tevc_trig #(
  parameter int ID_W   = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_en_i,
  input  logic              evt0_i,
  input  logic [ID_W-1:0]   trace_id_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int PAD_W = DATA_W - ID_W;

  function automatic logic [DATA_W-1:0] widen_id(input logic [ID_W-1:0] id);
    return DATA_W'(id);
  endfunction

  logic              pend_q;
  logic [DATA_W-1:0] data_q;
  logic              raise;
  logic              accept;

  assign raise  = trig_en_i & evt0_i & ~pend_q;
  assign accept = pend_q & ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (raise) begin
      pend_q <= 1'b1;
      data_q <= widen_id(trace_id_i);
    end else if (accept) begin
      pend_q <= 1'b0;
    end
  end

  assign valid_o = pend_q;
  assign data_o  = data_q;

  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (rst)
    pend_q && !ready_i |=> pend_q); // R6
  AST_TRIG_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !pend_q); // R7
  AST_TRIG_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    pend_q && !ready_i |=> $stable(data_q)); // R8

  if (PAD_W > 0) begin : g_pad
    AST_TRIG_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      data_q[DATA_W-1:ID_W] == '0); // R8
  end else if (PAD_W < 0) begin : g_bad
    initial $error("tevc_trig: DATA_W must be at least ID_W");
  end
endmodule

// File: rtl/tevc_top.sv
`timescale 1ns/1ps
module tevc_top
  import tevc_pkg::*;
#(
  parameter int ID_W   = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_oe_i,
  input  logic              cap_lpo_i,
  input  logic              cap_trig_i,
  input  logic              idle_i,
  input  logic              wr_en_i,
  input  logic [63:0]       wr_data_i,
  output logic [63:0]       rd_data_o,
  output logic              wr_err_o,
  input  logic [3:0]        evt_i,
  output logic [3:0]        elem_o,
  input  logic [ID_W-1:0]   trace_id_i,
  output logic              trig_valid_o,
  input  logic              trig_ready_i,
  output logic [DATA_W-1:0] trig_data_o,
  output logic              out_en_o,
  output logic              lp_override_o
);
  ctl_t ctl;

  tevc_ctl_reg u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cap_oe_i  (cap_oe_i),
    .cap_lpo_i (cap_lpo_i),
    .cap_trig_i(cap_trig_i),
    .idle_i    (idle_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .ctl_o     (ctl),
    .wr_err_o  (wr_err_o)
  );

  tevc_evt_gate #(.N(NUM_EVT)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .evt_i (evt_i),
    .en_i  (ctl.evt_en),
    .elem_o(elem_o)
  );

  tevc_trig #(.ID_W(ID_W), .DATA_W(DATA_W)) u_trig (
    .clk       (clk),
    .rst       (rst),
    .trig_en_i (ctl.trig_en),
    .evt0_i    (evt_i[0]),
    .trace_id_i(trace_id_i),
    .ready_i   (trig_ready_i),
    .valid_o   (trig_valid_o),
    .data_o    (trig_data_o)
  );

  assign out_en_o      = ctl.out_en;
  assign lp_override_o = ctl.lp_ovr;

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[63:14] == '0 && rd_data_o[10:4] == '0); // R2
  AST_TRIG_NEEDS_CAP: assert property (@(posedge clk) disable iff (rst)
    !trig_valid_o && !cap_trig_i |=> !trig_valid_o); // R3
  AST_OE_NEEDS_CAP: assert property (@(posedge clk) disable iff (rst)
    out_en_o |-> cap_oe_i); // R4
endmodule

// File: tb/tevc_top_tb_top.sv
`timescale 1ns/1ps
module tevc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W   = 7;
  localparam int DATA_W = 32;
  localparam int NV     = 6;

  // caps order {oe, lpo, trig}
  localparam logic [2:0]  V_CAP [NV] = '{3'b111, 3'b000, 3'b100, 3'b010, 3'b001, 3'b111};
  localparam logic [63:0] V_WR  [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
                                         64'h0000_0000_0000_2000, 64'h0000_0000_0000_3000,
                                         64'hFFFF_0000_0000_0805, 64'h0000_0000_0000_07F0};
  localparam logic [63:0] V_RD  [NV] = '{64'h380F, 64'h000F, 64'h2000, 64'h1000, 64'h0805, 64'h0000};
  localparam logic [1:0]  V_OL  [NV] = '{2'b11, 2'b00, 2'b10, 2'b01, 2'b00, 2'b00};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_oe = 1'b0, cap_lpo = 1'b0, cap_trig = 1'b0;
  logic idle = 1'b1, wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic wr_err;
  logic [3:0] evt = '0;
  logic [3:0] elem;
  logic [ID_W-1:0] tid = '0;
  logic trig_valid, trig_ready = 1'b0;
  logic [DATA_W-1:0] trig_data;
  logic out_en, lp_ovr;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tevc_top #(.ID_W(ID_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .cap_oe_i(cap_oe), .cap_lpo_i(cap_lpo), .cap_trig_i(cap_trig),
    .idle_i(idle), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .wr_err_o(wr_err), .evt_i(evt), .elem_o(elem), .trace_id_i(tid),
    .trig_valid_o(trig_valid), .trig_ready_i(trig_ready), .trig_data_o(trig_data),
    .out_en_o(out_en), .lp_override_o(lp_ovr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rd", rd_data, 64'h0);
    chk("R1 elem", 64'(elem), 64'h0);
    chk("R1 trig_valid", 64'(trig_valid), 64'h0);
    chk("R1 wr_err", 64'(wr_err), 64'h0);
    chk("R1 oe/lpo", 64'({out_en, lp_ovr}), 64'h0);

    // table: R2 reserved, R3 caps, R4 exported bits, R10 readback
    for (int i = 0; i < NV; i++) begin
      {cap_oe, cap_lpo, cap_trig} = V_CAP[i];
      wr(V_WR[i]);
      chk("R2/R3/R10 rd", rd_data, V_RD[i]);
      chk("R4 oe/lpo", 64'({out_en, lp_ovr}), 64'(V_OL[i]));
    end

    // R3: caps removed after write hides the fields
    {cap_oe, cap_lpo, cap_trig} = 3'b111;
    wr(64'h380F);
    {cap_oe, cap_lpo, cap_trig} = 3'b000;
    #1;
    chk("R3 caps dropped", rd_data, 64'h000F);
    chk("R4 caps dropped", 64'({out_en, lp_ovr}), 64'h0);
    {cap_oe, cap_lpo, cap_trig} = 3'b111;

    // element and trigger in the same cycle: R5, R6, R8
    wr(64'h0805);
    evt = 4'b1111; tid = 7'h55;
    @(negedge clk);
    evt = 4'b0000;
    chk("R5 elem gated", 64'(elem), 64'h5);
    chk("R6 trig raised", 64'(trig_valid), 64'h1);
    chk("R8 trig data", 64'(trig_data), 64'h55);
    @(negedge clk);
    chk("R5 elem one cycle", 64'(elem), 64'h0);
    chk("R6 trig held", 64'(trig_valid), 64'h1);

    // R7 fold while pending
    evt = 4'b0001; tid = 7'h2A;
    @(negedge clk);
    evt = 4'b0000;
    chk("R7 still pending", 64'(trig_valid), 64'h1);
    chk("R8 data unchanged", 64'(trig_data), 64'h55);
    // R7 pulse in acceptance cycle is folded
    evt = 4'b0001; tid = 7'h11; trig_ready = 1'b1;
    @(negedge clk);
    evt = 4'b0000; trig_ready = 1'b0;
    chk("R7 dropped after accept", 64'(trig_valid), 64'h0);
    @(negedge clk);
    chk("R7 no re-raise", 64'(trig_valid), 64'h0);
    // R6 new trigger
    evt = 4'b0001; tid = 7'h7F;
    @(negedge clk);
    evt = 4'b0000;
    chk("R6 new trigger", 64'(trig_valid), 64'h1);
    chk("R8 new id zero-ext", 64'(trig_data), 64'h7F);
    trig_ready = 1'b1;
    @(negedge clk);
    trig_ready = 1'b0;
    chk("R6 accepted", 64'(trig_valid), 64'h0);

    // R6 trigger enable clear: element only
    wr(64'h0001);
    evt = 4'b0001;
    @(negedge clk);
    evt = 4'b0000;
    chk("R5 elem0 only", 64'(elem), 64'h1);
    chk("R6 no trig when disabled", 64'(trig_valid), 64'h0);

    // R3 trigger capability absent
    wr(64'h0800);
    cap_trig = 1'b0;
    evt = 4'b0001;
    @(negedge clk);
    evt = 4'b0000;
    chk("R3 no trig without cap", 64'(trig_valid), 64'h0);
    chk("R5 elem disabled", 64'(elem), 64'h0);
    cap_trig = 1'b1;

    // R9 busy write
    #1;
    chk("R9 before busy", rd_data, 64'h0800);
    idle = 1'b0;
    wr(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R9 write dropped", rd_data, 64'h0800);
    chk("R9 err set", 64'(wr_err), 64'h1);
    idle = 1'b1;
    wr(64'h0002);
    chk("R10 idle write", rd_data, 64'h0002);
    chk("R9 err sticky", 64'(wr_err), 64'h1);

    summary();
    $finish;
  end
endmodule